// File: doc/BRIEF.md
# PLL Reconfiguration Register Bridge

This block sits on a 32-bit memory-mapped register bus and gives host software indirect access to the dynamic reconfiguration port of a clock-synthesis PLL. The PLL's internal registers are not mapped to bus addresses one by one. Instead, software writes a single command word, and that word launches one complete port transaction: either a read or a write of one 16-bit PLL register.

A status register reports whether a transaction is still in flight. The same register returns the data captured by the most recent completed read. Software polls the in-flight flag before it launches a command, and polls it again before it collects read data.

A third register drives the PLL's power-down reset and a general reset-release line. Every register clears to zero on bus reset, so the PLL comes up held in reset.

Register offsets and fields:

- Command register at byte offset 0x70:
  - bit 29: port select. A command runs only when this bit is set.
  - bit 28: read flag. 1 means read, 0 means write.
  - bits 22:16: PLL register address.
  - bits 15:0: write data.
- Status register at byte offset 0x74:
  - bit 16: in flight.
  - bits 15:0: last read data.
- Reset register at byte offset 0x40:
  - bit 0: reset release.
  - bit 1: PLL enable. The PLL reset output is asserted while this bit is 0.

Bus reads have one cycle of latency. Data appears on the cycle after the read strobe.

Top module: `pll_cfg_bridge`

## Requirements
- R1: After bus reset, the PLL reset output is 1 and the release output is 0. The port enable and write-enable outputs are 0. Status reads as 0x00000000.
- R2: A write to offset 0x40 stores bits 1:0 of the written word. The release output follows bit 0. The PLL reset output is 1 exactly while the stored bit 1 is 0. Reading 0x40 returns the two stored bits in bits 1:0, with all other bits 0.
- R3: An accepted command asserts the port enable for exactly one cycle. This is the cycle after the write strobe. In that cycle the address output carries bits 22:16 of the command and the data output carries bits 15:0. Write enable is 1 in that cycle only when bit 28 of the command is 0.
- R4: Status bit 16 reads 1 from the cycle after an accepted command until the cycle after the PLL returns ready. It then reads 0.
- R5: For a read command, the PLL data input is captured on the ready pulse and returned in status bits 15:0. A write command leaves status bits 15:0 unchanged.
- R6: A command write with bit 29 equal to 0 starts no transaction and leaves status bit 16 at 0.
- R7: A command write that arrives while status bit 16 is 1 is dropped. The address output, the data output and the in-flight transaction are left unchanged.
- R8: A ready pulse that arrives while no transaction is in flight changes neither status bit.
- R9: Reading an unmapped offset returns 0. Reading 0x70 returns the last accepted command, masked to bits 29, 28, 22:16 and 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Active-low synchronous bus reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| drp_en | output | 1 | Port enable pulse |
| drp_we | output | 1 | Port write enable |
| drp_addr | output | DRP_AW | PLL register address |
| drp_di | output | DRP_DW | Data written to the PLL |
| drp_do | input | DRP_DW | Data read from the PLL |
| drp_rdy | input | 1 | PLL transaction done |
| pll_rst | output | 1 | PLL reset, active high |
| cfg_release | output | 1 | General reset-release line |

## Verification
The bench builds the bridge with its default parameters: an 8-bit offset, a 7-bit PLL address and 16-bit PLL data. This covers the full command field layout, including the highest PLL address, 0x7F. The bench plays the PLL itself, choosing when to return ready. It can therefore hold a transaction open while it issues stray commands, read back status and deliver a ready pulse while the bridge is idle.

// File: rtl/pll_cfg_bridge.sv
module pll_cfg_bridge #(
  parameter int ADDR_W = 8,
  parameter int DRP_AW = 7,
  parameter int DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy,
  output logic              pll_rst,
  output logic              cfg_release
);
  localparam logic [ADDR_W-1:0] OFF_RST = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] OFF_CMD = ADDR_W'('h70);
  localparam logic [ADDR_W-1:0] OFF_STS = ADDR_W'('h74);
  localparam int SEL_BIT  = 29;
  localparam int RD_BIT   = 28;
  localparam int ADDR_LSB = 16;
  localparam int BUSY_BIT = 16;
  localparam logic [31:0] CMD_MASK = (32'd1 << SEL_BIT) | (32'd1 << RD_BIT)
    | (((32'd1 << DRP_AW) - 32'd1) << ADDR_LSB) | ((32'd1 << DRP_DW) - 32'd1);

  logic [1:0]        rst_q;
  logic              busy, rd_op;
  logic [DRP_DW-1:0] rd_data;
  logic [31:0]       cmd_q;

  wire cmd_hit = bus_wr && (bus_addr == OFF_CMD);
  wire launch  = cmd_hit && bus_wdata[SEL_BIT] && !busy;
  wire done    = busy && drp_rdy;

  assign pll_rst     = ~rst_q[1];
  assign cfg_release = rst_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q    <= '0;
      busy     <= 1'b0;
      rd_op    <= 1'b0;
      rd_data  <= '0;
      cmd_q    <= '0;
      drp_en   <= 1'b0;
      drp_we   <= 1'b0;
      drp_addr <= '0;
      drp_di   <= '0;
    end else begin
      drp_en <= launch;
      drp_we <= launch && !bus_wdata[RD_BIT];
      if (launch) begin
        busy     <= 1'b1;
        rd_op    <= bus_wdata[RD_BIT];
        drp_addr <= bus_wdata[ADDR_LSB +: DRP_AW];
        drp_di   <= bus_wdata[DRP_DW-1:0];
        cmd_q    <= bus_wdata & CMD_MASK;
      end else if (done) begin
        busy <= 1'b0;
        if (rd_op) rd_data <= drp_do;
      end
      if (bus_wr && bus_addr == OFF_RST) rst_q <= bus_wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFF_RST: bus_rdata <= {30'd0, rst_q};
        OFF_CMD: bus_rdata <= cmd_q;
        OFF_STS: bus_rdata <= (32'(busy) << BUSY_BIT) | 32'(rd_data);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_en_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en);
  assert_we_with_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drp_we |-> drp_en);
  assert_en_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> busy);
  assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && drp_rdy) |=> !busy);
  assert_no_sel_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !bus_wdata[SEL_BIT]) |=> !drp_en);
  assert_drop_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(drp_addr) && $stable(drp_di)));
  assert_idle_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && drp_rdy && !launch) |=> ($stable(rd_data) && !busy));
  assert_pll_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_RST && bus_wdata[1]) |=> !pll_rst);
endmodule

// File: tb/tb_pll_cfg_bridge.sv
`timescale 1ns/1ps
module tb_pll_cfg_bridge;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, drp_rdy = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic drp_en, drp_we, pll_rst, cfg_release;
  logic [6:0] drp_addr;
  logic [15:0] drp_di, drp_do = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pll_cfg_bridge dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr), .drp_di(drp_di),
    .drp_do(drp_do), .drp_rdy(drp_rdy), .pll_rst(pll_rst), .cfg_release(cfg_release));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic rdy_pulse(input logic [15:0] d);
    drp_do = d; drp_rdy = 1;
    @(negedge clk);
    drp_rdy = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pll_rst", pll_rst, 1); chk("R1 release", cfg_release, 0);
    chk("R1 en", drp_en, 0); chk("R1 we", drp_we, 0);
    rd(8'h74, v); chk("R1 status", v, 0);
  endtask

  task automatic t_rst_reg();
    logic [31:0] v;
    wr(8'h40, 32'hFFFF_FFFD); chk("R2 pll_rst held", pll_rst, 1); chk("R2 release", cfg_release, 1);
    rd(8'h40, v); chk("R2 readback", v, 32'h1);
    wr(8'h40, 32'h3); chk("R2 pll_rst off", pll_rst, 0);
    rd(8'h40, v); chk("R2 readback", v, 32'h3);
  endtask

  task automatic t_write_txn();
    logic [31:0] v;
    wr(8'h70, 32'h204E_1234);
    chk("R3 en", drp_en, 1); chk("R3 we", drp_we, 1);
    chk("R3 addr", drp_addr, 7'h4E); chk("R3 di", drp_di, 16'h1234);
    @(negedge clk); chk("R3 en pulse", drp_en, 0); chk("R3 we pulse", drp_we, 0);
    rd(8'h74, v); chk("R4 busy", v, 32'h0001_0000);
    rdy_pulse(16'hDEAD);
    rd(8'h74, v); chk("R5 write keeps data, R4 idle", v, 0);
    rd(8'h70, v); chk("R9 cmd readback", v, 32'h204E_1234);
  endtask

  task automatic t_read_txn();
    logic [31:0] v;
    wr(8'h70, 32'h317F_FFFF);
    chk("R3 read en", drp_en, 1); chk("R3 read we", drp_we, 0);
    chk("R3 addr max", drp_addr, 7'h7F);
    rd(8'h74, v); chk("R4 busy read", v, 32'h0001_0000);
    rdy_pulse(16'hBEEF);
    rd(8'h74, v); chk("R5 read data", v, 32'h0000_BEEF);
  endtask

  task automatic t_no_sel();
    logic [31:0] v;
    wr(8'h70, 32'h1016_5555);
    chk("R6 no en", drp_en, 0);
    rd(8'h74, v); chk("R6 not busy", v, 32'h0000_BEEF);
  endtask

  task automatic t_drop();
    logic [31:0] v;
    wr(8'h70, 32'h3016_0000);
    wr(8'h70, 32'h2001_AAAA);
    chk("R7 no second en", drp_en, 0);
    chk("R7 addr kept", drp_addr, 7'h16); chk("R7 di kept", drp_di, 0);
    rd(8'h74, v); chk("R7 still busy", v, 32'h0001_BEEF);
    rdy_pulse(16'h0C0F);
    rd(8'h74, v); chk("R7 original read done", v, 32'h0000_0C0F);
  endtask

  task automatic t_idle_rdy();
    logic [31:0] v;
    rdy_pulse(16'h9999);
    rd(8'h74, v); chk("R8 idle ready ignored", v, 32'h0000_0C0F);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h44, v); chk("R9 unmapped", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_rst_reg(); t_write_txn(); t_read_txn();
    t_no_sel(); t_drop(); t_idle_rdy(); t_unmapped();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule